// File: doc/BRIEF.md
# Microcoded Control Sequencer with Opcode Dispatch

This block is the control unit of a multicycle processor, built as a microprogram. A 4-bit micro-program counter (micro-PC) selects one of ten microwords from a constant control store. Each microword carries 16 datapath control bits and a 2-bit sequencing code. The sequencing code tells the address-select logic how to form the next micro-address. It can return to the fetch word, look the address up in one of two opcode-indexed dispatch tables, or step to the next word in numerical order.

The next micro-address is never stored in the microword. Any states that follow one another are numbered consecutively, so the incrementer can reach them. Only the decode step and the memory-address step branch on the opcode. The control bits of each word match, cycle for cycle, the outputs of the equivalent hardwired state machine.

The micro-PC is a register. The control outputs are decoded from it without a register, so they change in the same cycle as the micro-PC.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the micro-PC becomes 0 at that edge. Afterwards `upc` reads 0 and `ctrl` reads 16'h9408.
- R2: `ctrl` is a function of `upc` alone, according to this table:
  - State 0: 9408
  - State 1: 0018
  - State 2: 0014
  - State 3: 3000
  - State 4: 0202
  - State 5: 2800
  - State 6: 0044
  - State 7: 0003
  - State 8: 40A4
  - State 9: 8100
- R3: From micro-address 0 the next micro-address is always 1, whatever the opcode.
- R4: From micro-address 1 the next address comes from the first dispatch table, indexed by the opcode present at that edge. The table maps:
  - 6'h23 and 6'h2B to 2
  - 6'h00 to 6
  - 6'h04 to 8
  - 6'h02 to 9
- R5: From micro-address 2 the next address comes from the second dispatch table. It maps 6'h23 to 3 and 6'h2B to 5.
- R6: Micro-addresses 3 and 6 step to the numerically following address, 4 and 7.
- R7: Micro-addresses 4, 5, 7, 8 and 9 return to 0 at the next edge.
- R8: Any opcode without an entry in a dispatch table sends the micro-PC to 0. This holds for table 1 at address 1 and for table 2 at address 2.
- R9: An instruction that starts at address 0 with a steady opcode takes the following number of cycles before `upc` is 0 again:
  - 6'h23: 5 cycles
  - 6'h2B: 4 cycles
  - 6'h00: 4 cycles
  - 6'h04: 3 cycles
  - 6'h02: 3 cycles
- R10: The field positions in `ctrl` are as follows:
  - bit 15: PC write
  - bit 14: conditional PC write
  - bit 13: memory address from the ALU register
  - bit 12: memory read
  - bit 11: memory write
  - bit 10: instruction register write
  - bit 9: write-back from memory data
  - bits 8:7: PC source
  - bits 6:5: ALU operation
  - bits 4:3: ALU B select
  - bit 2: ALU A select
  - bit 1: register file write
  - bit 0: destination register select

  Memory read and memory write are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the current instruction |
| ctrl | output | 16 | Datapath control bits of the current microword |
| upc | output | 4 | Current micro-PC, for observation |

## Verification
Each of the five known opcodes is run through a full instruction. The bench checks the micro-PC and the control bits in every state, so each instruction tells apart one path through both dispatch tables, the two increment steps and the return to fetch. An opcode with no table entry shows that the first table falls back to 0. A load opcode that is replaced by a register opcode between decode and address computation shows that the second table reads the opcode live at its own edge and also falls back to 0. Back-to-back instructions confirm the cycle counts and that fetch ignores the opcode.

// File: rtl/useq_pkg.sv
// Package: shared widths, microword types and the constant tables of the
// sequencer. Assumes opcodes are 6 bits and at most 16 micro-addresses.
package useq_pkg;
    localparam int OP_W      = 6;
    localparam int UPC_W     = 4;
    localparam int CTRL_W    = 16;
    localparam int ROM_WORDS = 10;
    localparam int NUM_DISP  = 2;
    localparam int OP_SPAN   = 1 << OP_W;

    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;

    // Sequencing code held in each microword
    typedef enum logic [1:0] {
        SEQ_ZERO  = 2'd0,
        SEQ_DISP1 = 2'd1,
        SEQ_DISP2 = 2'd2,
        SEQ_NEXT  = 2'd3
    } seq_code_e;

    // Datapath control bits, MSB first
    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       wb_sel;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic [1:0] alu_b;
        logic       alu_a;
        logic       rf_wr;
        logic       rf_dst;
    } ctrl_t;

    typedef struct packed {
        ctrl_t     ctrl;
        seq_code_e seq;
    } uword_t;

    // Control-store contents for one micro-address
    function automatic uword_t rom_word(input logic [UPC_W-1:0] a);
        uword_t w;
        w = '0;
        w.seq = SEQ_ZERO;
        case (a)
            4'd0: begin
                w.ctrl.pc_wr = 1'b1; w.ctrl.mem_rd = 1'b1;
                w.ctrl.ir_wr = 1'b1; w.ctrl.alu_b = 2'b01;
                w.seq = SEQ_NEXT;
            end
            4'd1: begin
                w.ctrl.alu_b = 2'b11; w.seq = SEQ_DISP1;
            end
            4'd2: begin
                w.ctrl.alu_a = 1'b1; w.ctrl.alu_b = 2'b10;
                w.seq = SEQ_DISP2;
            end
            4'd3: begin
                w.ctrl.mem_rd = 1'b1; w.ctrl.addr_sel = 1'b1;
                w.seq = SEQ_NEXT;
            end
            4'd4: begin
                w.ctrl.rf_wr = 1'b1; w.ctrl.wb_sel = 1'b1;
            end
            4'd5: begin
                w.ctrl.mem_wr = 1'b1; w.ctrl.addr_sel = 1'b1;
            end
            4'd6: begin
                w.ctrl.alu_a = 1'b1; w.ctrl.alu_op = 2'b10;
                w.seq = SEQ_NEXT;
            end
            4'd7: begin
                w.ctrl.rf_wr = 1'b1; w.ctrl.rf_dst = 1'b1;
            end
            4'd8: begin
                w.ctrl.alu_a = 1'b1; w.ctrl.alu_op = 2'b01;
                w.ctrl.pc_wr_cond = 1'b1; w.ctrl.pc_src = 2'b01;
            end
            4'd9: begin
                w.ctrl.pc_wr = 1'b1; w.ctrl.pc_src = 2'b10;
            end
            default: w = '0;
        endcase
        return w;
    endfunction

    // Dispatch table lookup; tsel 0 is the decode table, 1 the address table
    function automatic logic [UPC_W-1:0] disp_entry(input int tsel,
                                                    input logic [OP_W-1:0] op);
        logic [UPC_W-1:0] r;
        r = '0;
        if (tsel == 0) begin
            case (op)
                OPC_LOAD, OPC_STORE: r = 4'd2;
                OPC_RTYPE:           r = 4'd6;
                OPC_BEQ:             r = 4'd8;
                OPC_JUMP:            r = 4'd9;
                default:             r = '0;
            endcase
        end else begin
            case (op)
                OPC_LOAD:  r = 4'd3;
                OPC_STORE: r = 4'd5;
                default:   r = '0;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/useq_ctrl_rom.sv
// Control store: maps a micro-address to its microword. Purely combinational.
// Assumes addresses at or above ROM_WORDS are unreachable; they read as zero.
module useq_ctrl_rom
    import useq_pkg::*;
#(
    parameter int DEPTH = ROM_WORDS
) (
    input  logic [UPC_W-1:0] addr,
    output uword_t           word
);
    localparam int TABLE_N = (DEPTH < (1 << UPC_W)) ? DEPTH : (1 << UPC_W);

    uword_t table_q [TABLE_N];

    // Build the constant table, one entry per micro-address
    for (genvar i = 0; i < TABLE_N; i++) begin : g_word
        assign table_q[i] = rom_word(UPC_W'(i));
    end

    // Read the addressed word, zero when out of range
    always_comb begin
        if (int'(addr) < TABLE_N) word = table_q[addr];
        else                      word = '0;
    end
endmodule

// File: rtl/useq_dispatch.sv
// One opcode-indexed dispatch table. TSEL chooses which constant table.
// Assumes every opcode value has an entry; unlisted ones give address 0.
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int TSEL = 0
) (
    input  logic [OP_W-1:0]  opcode,
    output logic [UPC_W-1:0] target
);
    // Look up the target micro-address for this opcode
    always_comb begin
        target = disp_entry(TSEL, opcode);
    end
endmodule

// File: rtl/useq_next_addr.sv
// Next micro-address select: zero, either dispatch result, or increment.
// Assumes the dispatch targets are already resolved for the current opcode.
module useq_next_addr
    import useq_pkg::*;
(
    input  logic [UPC_W-1:0] cur,
    input  seq_code_e        seq,
    input  logic [UPC_W-1:0] disp_tgt [NUM_DISP],
    output logic [UPC_W-1:0] nxt
);
    logic [UPC_W-1:0] inc;

    // Sequential successor
    always_comb begin
        inc = cur + UPC_W'(1);
    end

    // Four-way select on the sequencing code
    always_comb begin
        case (seq)
            SEQ_ZERO:  nxt = '0;
            SEQ_DISP1: nxt = disp_tgt[0];
            SEQ_DISP2: nxt = disp_tgt[1];
            SEQ_NEXT:  nxt = inc;
            default:   nxt = '0;
        endcase
    end
endmodule

// File: rtl/useq_sequencer.sv
// Top: micro-PC register, control store, dispatch tables and address select.
// Assumes opcode is stable around the rising edge; reset is synchronous low.
module useq_sequencer
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    output logic [CTRL_W-1:0] ctrl,
    output logic [UPC_W-1:0]  upc
);
    logic [UPC_W-1:0] upc_q;
    logic [UPC_W-1:0] upc_d;
    logic [UPC_W-1:0] disp_tgt [NUM_DISP];
    uword_t           cur_word;

    useq_ctrl_rom #(.DEPTH(ROM_WORDS)) u_rom (
        .addr (upc_q),
        .word (cur_word)
    );

    for (genvar t = 0; t < NUM_DISP; t++) begin : g_disp
        useq_dispatch #(.TSEL(t)) u_disp (
            .opcode (opcode),
            .target (disp_tgt[t])
        );
    end

    useq_next_addr u_nxt (
        .cur      (upc_q),
        .seq      (cur_word.seq),
        .disp_tgt (disp_tgt),
        .nxt      (upc_d)
    );

    // Micro-PC register with synchronous reset to the fetch word
    always_ff @(posedge clk) begin
        if (!rst_n) upc_q <= '0;
        else        upc_q <= upc_d;
    end

    // Drive the observed outputs
    always_comb begin
        ctrl = cur_word.ctrl;
        upc  = upc_q;
    end
endmodule

// File: rtl/useq_sequencer_chk.sv
// Checker bound to the sequencer: sequencing rules at the ports.
// Assumes it sees the top-level ports only.
module useq_sequencer_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   opcode,
    input logic [CTRL_W-1:0] ctrl,
    input logic [UPC_W-1:0]  upc
);
    p_reset_r1: assert property (@(posedge clk) !rst_n |=> upc == 4'd0);

    p_fetch_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 4'd0 |-> ctrl == 16'h9408);

    p_fetch_to_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 4'd0 |=> upc == 4'd1);

    p_disp1_rtype_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 4'd1 && opcode == 6'h00) |=> upc == 4'd6);

    p_disp1_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 4'd1 && (opcode == 6'h23 || opcode == 6'h2B)) |=> upc == 4'd2);

    p_disp2_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 4'd2 && opcode == 6'h23) |=> upc == 4'd3);

    p_disp2_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 4'd2 && opcode == 6'h2B) |=> upc == 4'd5);

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 4'd3 || upc == 4'd6) |=> upc == $past(upc) + 4'd1);

    p_terminal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 4'd4 || upc == 4'd5 || upc == 4'd7 || upc == 4'd8 || upc == 4'd9)
        |=> upc == 4'd0);

    p_disp2_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 4'd2 && opcode != 6'h23 && opcode != 6'h2B) |=> upc == 4'd0);

    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upc < 4'd10);

    p_mem_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl[12] && ctrl[11]));
endmodule

bind useq_sequencer useq_sequencer_chk u_chk (.*);

// File: tb/useq_sequencer_bench.sv
// Directed bench for the microcoded sequencer.
module useq_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = 6'h00;
    logic [15:0] ctrl;
    logic [3:0]  upc;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    useq_sequencer u_useq_sequencer (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .ctrl   (ctrl),
        .upc    (upc)
    );

    always #4 clk = ~clk;

    // Expected control bits per state, from the R2 table
    function automatic logic [15:0] exp_ctrl(input int s);
        case (s)
            0: return 16'h9408;  1: return 16'h0018;  2: return 16'h0014;
            3: return 16'h3000;  4: return 16'h0202;  5: return 16'h2800;
            6: return 16'h0044;  7: return 16'h0003;  8: return 16'h40A4;
            9: return 16'h8100;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Check state and its control word, then advance one cycle
    task automatic step(input string req, input int s);
        check(req, {12'h0, upc}, 16'(s));
        check({req, "/R2"}, ctrl, exp_ctrl(s));
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 upc", {12'h0, upc}, 16'h0000);
        check("R1 ctrl", ctrl, 16'h9408);
        rst_n = 1'b1;
    endtask

    task automatic t_load();
        opcode = 6'h23;
        step("R3 load", 0); step("R4 load", 1); step("R5 load", 2);
        step("R6 load", 3); step("R7 load", 4);
        check("R9 load end", {12'h0, upc}, 16'h0000);
    endtask

    task automatic t_store();
        opcode = 6'h2B;
        step("R3 store", 0); step("R4 store", 1); step("R5 store", 2);
        step("R7 store", 5);
        check("R9 store end", {12'h0, upc}, 16'h0000);
    endtask

    task automatic t_rtype();
        opcode = 6'h00;
        step("R3 rtype", 0); step("R4 rtype", 1); step("R6 rtype", 6);
        step("R7 rtype", 7);
        check("R9 rtype end", {12'h0, upc}, 16'h0000);
    endtask

    task automatic t_branch();
        opcode = 6'h04;
        step("R3 beq", 0); step("R4 beq", 1); step("R7 beq", 8);
        check("R9 beq end", {12'h0, upc}, 16'h0000);
    endtask

    task automatic t_jump();
        opcode = 6'h02;
        step("R3 jump", 0); step("R4 jump", 1); step("R7 jump", 9);
        check("R9 jump end", {12'h0, upc}, 16'h0000);
    endtask

    task automatic t_unused_op();
        opcode = 6'h3F;
        step("R3 unused", 0); step("R8 unused disp1", 1);
        check("R8 unused end", {12'h0, upc}, 16'h0000);
    endtask

    task automatic t_op_switch();
        opcode = 6'h23;
        step("R3 switch", 0); step("R4 switch", 1);
        opcode = 6'h00;
        step("R8 switch disp2", 2);
        check("R8 switch end", {12'h0, upc}, 16'h0000);
    endtask

    task automatic t_fetch_ignores_op();
        opcode = 6'h3F;
        check("R3 at fetch", {12'h0, upc}, 16'h0000);
        @(posedge clk); @(negedge clk);
        check("R3 any opcode", {12'h0, upc}, 16'h0001);
        opcode = 6'h04;
        step("R4 after any", 1);
        step("R7 after any", 8);
    endtask

    task automatic t_fields();
        opcode = 6'h23;
        for (int s = 0; s < 5; s++) begin
            check("R10 mem excl", {15'h0, ctrl[12] & ctrl[11]}, 16'h0000);
            if (s == 3) check("R10 read field", {15'h0, ctrl[12]}, 16'h0001);
            if (s == 4) check("R10 rf write", {15'h0, ctrl[1]}, 16'h0001);
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_store();
        t_rtype();
        t_branch();
        t_jump();
        t_unused_op();
        t_op_switch();
        t_fetch_ignores_op();
        t_fields();
        t_load();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule